// File: doc/BRIEF.md
# Command-Sequenced SRAM Controller

This block accepts a stream of 32-bit command words, one per rising clock edge and with no handshake, and turns each command into accesses on a single-port SRAM. The first word of every command carries a 4-bit opcode in its top nibble. Any address and data words follow on the clocks right after it. The block supports no-op, control-register load, single-word write, four-word burst write and single-word read. It rejects opcodes it does not know.

All SRAM-side signals come from registers. A write strobe goes low for one cycle, starting at the edge that takes in the data word. A read strobe goes low for one cycle, starting at the edge that takes in the address word. The returned data is captured into the result register at the edge that ends the read strobe. The 8-bit control register and a sticky error flag are visible on a separate status output.

Top module: `sramc_top`

## Requirements
- R1: A synchronous active-low reset returns the sequencer to idle. It drives both strobes high and clears the result word, the control byte and the error flag to zero. A command in progress is abandoned.
- R2: Only a word taken in idle is decoded as an opcode. The opcode is bits 31:28, with these codes: 0x0 no-op, 0x1 control load, 0x2 single write, 0x3 burst write, 0x4 read.
- R3: A control load takes one following word. That word's bits 7:0 go into `ctl_state[7:0]` at the edge that takes the word. Its bits 31:8 have no effect.
- R4: A single write is the opcode word, an address word and a data word. At the edge that takes the data word, `mem_wr_n` goes low for exactly one cycle. During that cycle `mem_addr` holds the address and `mem_dq` carries the data.
- R5: A burst write is the opcode word, one address word and four data words on consecutive clocks. It produces four consecutive write-strobe cycles at the base address plus 0, 1, 2 and 3, wrapping modulo 1024.
- R6: A read is the opcode word and an address word. `mem_rd_n` goes low for one cycle at the edge that takes the address. The bus value is captured into `result` at the next edge. `result` keeps that value until the next read completes.
- R7: A no-op or an unknown opcode (0x5 through 0xF) uses one cycle and produces no strobe. An unknown opcode sets the error flag `ctl_state[8]`, and only reset clears it.
- R8: Address and data words inside a command are never decoded as opcodes, whatever their top bits hold.
- R9: Only bits 9:0 of an address word select the SRAM location. Bits 31:10 have no effect.
- R10: The controller drives `mem_dq` only while `mem_wr_n` is low and releases it at all other times. `mem_rd_n` and `mem_wr_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_in | input | 32 | Command, address or data word, one per clock |
| result | output | 32 | Last word read from the SRAM |
| ctl_state | output | 9 | Bit 8 sticky error flag, bits 7:0 control byte |
| mem_addr | output | 10 | SRAM address |
| mem_dq | inout | 32 | Shared SRAM data bus |
| mem_rd_n | output | 1 | SRAM read strobe, active low |
| mem_wr_n | output | 1 | SRAM write strobe, active low |

## Verification
The embedded properties assume that the SRAM drives `mem_dq` only while `mem_rd_n` is low, and that reset is held low for at least two clocks before any command is sent. They also assume each command arrives complete, with no gaps between its words. The bench drives words at the falling edge and keeps every command contiguous. Its SRAM model drives the bus only under the read strobe and stores the bus value at the rising edge while the write strobe is low. Reset is held low for three clocks at start-up and for two clocks when it is applied in the middle of a command.

// File: rtl/sramc_pkg.sv
// Package sramc_pkg
// Shared opcode codes and the sequencer state type for the SRAM command controller.
// Assumes a 4-bit opcode field in the top bits of a command word.
package sramc_pkg;
    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_NOP   = 4'h0;
    localparam logic [OP_W-1:0] OP_CTL   = 4'h1;
    localparam logic [OP_W-1:0] OP_WR    = 4'h2;
    localparam logic [OP_W-1:0] OP_BURST = 4'h3;
    localparam logic [OP_W-1:0] OP_RD    = 4'h4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CTL_DATA,
        S_WR_ADDR,
        S_WR_DATA,
        S_RD_ADDR
    } seq_st_e;
endpackage

// File: rtl/sramc_seq.sv
// Module sramc_seq
// Command sequencer. Decodes opcodes in idle, gathers the address and data
// words that follow, and produces registered SRAM address, write data and
// active-low strobes. Assumes each command's words arrive on consecutive clocks.
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 10,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cmd_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] wdata,
    output logic              wr_n,
    output logic              rd_n,
    output logic              ctl_load,
    output logic              bad_op
);
    localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

    seq_st_e            state_q;
    logic               burst_q;
    logic [BEAT_W-1:0]  beat_q;
    logic [ADDR_W-1:0]  base_q;
    logic [OP_W-1:0]    op_f;

    assign op_f = cmd_in[DATA_W-1 -: OP_W];

    // Pulse to the control register: the current word is a control payload.
    assign ctl_load = (state_q == S_CTL_DATA);
    // Pulse to the error flag: an unknown opcode is being taken in idle.
    assign bad_op   = (state_q == S_IDLE) && (op_f > OP_RD);

    // Sequencer state, beat counter and registered SRAM-side outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            burst_q  <= 1'b0;
            beat_q   <= '0;
            base_q   <= '0;
            mem_addr <= '0;
            wdata    <= '0;
            wr_n     <= 1'b1;
            rd_n     <= 1'b1;
        end else begin
            wr_n <= 1'b1;
            rd_n <= 1'b1;
            case (state_q)
                S_IDLE: begin
                    case (op_f)
                        OP_NOP:   state_q <= S_IDLE;
                        OP_CTL:   state_q <= S_CTL_DATA;
                        OP_WR:    begin burst_q <= 1'b0; state_q <= S_WR_ADDR; end
                        OP_BURST: begin burst_q <= 1'b1; state_q <= S_WR_ADDR; end
                        OP_RD:    state_q <= S_RD_ADDR;
                        default:  state_q <= S_IDLE;
                    endcase
                end
                S_CTL_DATA: state_q <= S_IDLE;
                S_WR_ADDR: begin
                    base_q  <= cmd_in[ADDR_W-1:0];
                    beat_q  <= '0;
                    state_q <= S_WR_DATA;
                end
                S_WR_DATA: begin
                    mem_addr <= base_q + ADDR_W'(beat_q);
                    wdata    <= cmd_in;
                    wr_n     <= 1'b0;
                    if (!burst_q || beat_q == LAST_BEAT) begin
                        state_q <= S_IDLE;
                    end else begin
                        beat_q <= beat_q + 1'b1;
                    end
                end
                S_RD_ADDR: begin
                    mem_addr <= cmd_in[ADDR_W-1:0];
                    rd_n     <= 1'b0;
                    state_q  <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R10: the two strobes are never active in the same cycle
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n && !rd_n));

    // R4: a write strobe only follows a cycle spent collecting a data word
    a_r4_wr_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> $past(state_q == S_WR_DATA));

    // R5: back-to-back write strobes step the address by one
    a_r5_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R6: the read strobe lasts a single cycle
    a_r6_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |=> rd_n);
endmodule

// File: rtl/sramc_ctl_reg.sv
// Module sramc_ctl_reg
// Control byte and sticky error flag. The byte loads when the sequencer
// marks a control payload. The flag sets on an unknown opcode and clears only on reset.
module sramc_ctl_reg #(
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_load,
    input  logic [CTRL_W-1:0] ctl_data,
    input  logic              bad_op,
    output logic [CTRL_W:0]   ctl_state
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              err_q;

    // Control byte load and sticky error capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (ctl_load) ctrl_q <= ctl_data;
            if (bad_op)   err_q  <= 1'b1;
        end
    end

    assign ctl_state = {err_q, ctrl_q};

    // R7: once set, the error flag stays set until reset
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_q) |-> err_q);

    // R3: the control byte changes only after a load pulse
    a_r3_ctrl_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> $past(ctl_load));
endmodule

// File: rtl/sramc_rd_cap.sv
// Module sramc_rd_cap
// Captures the SRAM data bus into the result register at the edge that ends
// the read strobe. Assumes the SRAM drives the bus while the read strobe is low.
module sramc_rd_cap #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] result
);
    // Result register, updated only at the end of a read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     result <= '0;
        else if (!rd_n) result <= bus_in;
    end

    // R6: the result holds unless a read strobe was active in the prior cycle
    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $past(!rd_n));
endmodule

// File: rtl/sramc_top.sv
// Module sramc_top
// SRAM command controller. Ties the sequencer, the control register and the
// read capture together, and drives the shared data bus during write strobes.
// Assumes an asynchronous-read SRAM that drives the bus only under the read strobe.
module sramc_top #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 10,
    parameter int CTRL_W    = 8,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cmd_in,
    output logic [DATA_W-1:0] result,
    output logic [CTRL_W:0]   ctl_state,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq,
    output logic              mem_rd_n,
    output logic              mem_wr_n
);
    logic [DATA_W-1:0] wdata;
    logic              ctl_load;
    logic              bad_op;

    sramc_seq #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .BURST_LEN (BURST_LEN)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_in   (cmd_in),
        .mem_addr (mem_addr),
        .wdata    (wdata),
        .wr_n     (mem_wr_n),
        .rd_n     (mem_rd_n),
        .ctl_load (ctl_load),
        .bad_op   (bad_op)
    );

    sramc_ctl_reg #(
        .CTRL_W (CTRL_W)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_load  (ctl_load),
        .ctl_data  (cmd_in[CTRL_W-1:0]),
        .bad_op    (bad_op),
        .ctl_state (ctl_state)
    );

    sramc_rd_cap #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_n   (mem_rd_n),
        .bus_in (mem_dq),
        .result (result)
    );

    // Bus driver: write data only while the write strobe is low.
    assign mem_dq = (!mem_wr_n) ? wdata : {DATA_W{1'bz}};
endmodule

// File: tb/tb_sramc_top.sv
`timescale 1ns/1ps
// Bench for sramc_top: a vector table walked by one loop, then directed tests.
module tb_sramc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cmd_in = 32'h0;
    logic [31:0] result;
    logic [8:0]  ctl_state;
    logic [9:0]  mem_addr;
    wire  [31:0] dq;
    logic        mem_rd_n, mem_wr_n;

    int total = 0;
    int bad   = 0;

    logic [31:0] mem [1024];

    localparam logic [31:0] W_NOP = 32'h0000_0000;
    localparam logic [31:0] W_CTL = 32'h1000_0000;
    localparam logic [31:0] W_WR  = 32'h2000_0000;
    localparam logic [31:0] W_BST = 32'h3000_0000;
    localparam logic [31:0] W_RD  = 32'h4000_0000;
    localparam logic [31:0] W_ILL = 32'h5000_0000;

    // Vector: {op[3:0], addr[9:0], data[31:0], expect[31:0]}
    localparam int NV = 10;
    localparam logic [77:0] VEC [NV] = '{
        {4'h1, 10'h000, 32'hFFFF_FFA5, 32'h0000_00A5},
        {4'h2, 10'h010, 32'h0000_00AA, 32'h0},
        {4'h2, 10'h020, 32'h0000_00BB, 32'h0},
        {4'h3, 10'h030, 32'h0000_00CC, 32'h0},
        {4'h4, 10'h010, 32'h0,         32'h0000_00AA},
        {4'h4, 10'h020, 32'h0,         32'h0000_00BB},
        {4'h4, 10'h030, 32'h0,         32'h0000_00CC},
        {4'h4, 10'h031, 32'h0,         32'h0000_00CD},
        {4'h4, 10'h033, 32'h0,         32'h0000_00CF},
        {4'h5, 10'h000, 32'h0,         32'h0000_01A5}
    };

    sramc_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_in    (cmd_in),
        .result    (result),
        .ctl_state (ctl_state),
        .mem_addr  (mem_addr),
        .mem_dq    (dq),
        .mem_rd_n  (mem_rd_n),
        .mem_wr_n  (mem_wr_n)
    );

    always #5 clk = ~clk;

    // SRAM model: asynchronous read under the read strobe, write at the edge.
    assign dq = (!mem_rd_n) ? mem[mem_addr] : 32'hzzzz_zzzz;
    always @(posedge clk) if (!mem_wr_n) mem[mem_addr] <= dq;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        cmd_in = w;
    endtask

    // Single write; checks the strobe cycle (R4, R10).
    task automatic do_wr(input logic [31:0] a, input logic [31:0] d);
        send(W_WR); send(a); send(d);
        @(negedge clk);
        chk("R4 wr strobe", {31'h0, mem_wr_n}, 32'h0);
        chk("R4 wr addr", {22'h0, mem_addr}, {22'h0, a[9:0]});
        chk("R10 bus carries wdata", dq, d);
        chk("R10 rd idle during wr", {31'h0, mem_rd_n}, 32'h1);
        cmd_in = W_NOP;
        @(negedge clk);
        chk("R4 wr one cycle", {31'h0, mem_wr_n}, 32'h1);
    endtask

    // Burst write; checks every beat address (R5).
    task automatic do_burst(input logic [31:0] a, input logic [31:0] d);
        send(W_BST); send(a);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk("R5 burst strobe", {31'h0, mem_wr_n}, 32'h0);
                chk("R5 burst addr", {22'h0, mem_addr}, {22'h0, a[9:0] + 10'(i - 1)});
            end
            cmd_in = d + 32'(i);
        end
        @(negedge clk);
        chk("R5 burst last strobe", {31'h0, mem_wr_n}, 32'h0);
        chk("R5 burst last addr", {22'h0, mem_addr}, {22'h0, a[9:0] + 10'd3});
        cmd_in = W_NOP;
        @(negedge clk);
        chk("R5 burst ends after four", {31'h0, mem_wr_n}, 32'h1);
    endtask

    // Read; checks the strobe then the captured result (R6).
    task automatic do_rd(input logic [31:0] a, input logic [31:0] exp);
        send(W_RD); send(a);
        @(negedge clk);
        chk("R6 rd strobe", {31'h0, mem_rd_n}, 32'h0);
        chk("R9 rd addr low bits", {22'h0, mem_addr}, {22'h0, a[9:0]});
        cmd_in = W_NOP;
        @(negedge clk);
        chk("R6 rd one cycle", {31'h0, mem_rd_n}, 32'h1);
        chk("R6 read result", result, exp);
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 1024; k++) mem[k] = 32'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset result", result, 32'h0);
        chk("R1 reset ctl", {23'h0, ctl_state}, 32'h0);
        chk("R1 reset wr_n", {31'h0, mem_wr_n}, 32'h1);
        chk("R1 reset rd_n", {31'h0, mem_rd_n}, 32'h1);
        rst_n = 1'b1;

        // Vector table walk (R2, R3, R4, R5, R6, R7)
        for (int v = 0; v < NV; v++) begin
            logic [3:0]  op;
            logic [31:0] ad, da, ex;
            op = VEC[v][77:74];
            ad = {22'h0, VEC[v][73:64]};
            da = VEC[v][63:32];
            ex = VEC[v][31:0];
            case (op)
                4'h1: begin
                    send(W_CTL); send(da);
                    @(negedge clk);
                    chk("R3 ctl byte load", {23'h0, ctl_state}, ex);
                    cmd_in = W_NOP;
                end
                4'h2: do_wr(ad, da);
                4'h3: do_burst(ad, da);
                4'h4: do_rd(ad, ex);
                default: begin
                    send(W_ILL);
                    @(negedge clk);
                    chk("R7 illegal sets error", {23'h0, ctl_state}, ex);
                    chk("R7 illegal no wr", {31'h0, mem_wr_n}, 32'h1);
                    chk("R7 illegal no rd", {31'h0, mem_rd_n}, 32'h1);
                    cmd_in = W_NOP;
                end
            endcase
        end

        // R7: no-ops give no strobe, error stays set; R6 result held
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            chk("R7 nop no wr", {31'h0, mem_wr_n}, 32'h1);
            chk("R7 nop no rd", {31'h0, mem_rd_n}, 32'h1);
        end
        chk("R7 error sticky", {23'h0, ctl_state}, 32'h0000_01A5);
        chk("R6 result holds", result, 32'h0000_00CF);

        // R9: upper address bits ignored
        do_wr(32'hFFFF_F3FF, 32'h1234_5678);
        do_rd(32'h0000_07FF, 32'h1234_5678);

        // R5: burst wraps modulo 1024
        do_burst(32'h0000_03FE, 32'h0000_0100);
        do_rd(32'h0000_0001, 32'h0000_0103);

        // R8: data word with control-op top bits is stored, not decoded
        do_wr(32'h0000_0050, 32'h1000_0077);
        chk("R8 data not decoded", {23'h0, ctl_state}, 32'h0000_01A5);
        do_rd(32'h0000_0050, 32'h1000_0077);

        // R1: reset in the middle of a command
        send(W_WR); send(32'h0000_0070);
        @(negedge clk);
        rst_n = 1'b0;
        cmd_in = 32'h0000_0099;
        repeat (2) @(negedge clk);
        chk("R1 mid reset ctl", {23'h0, ctl_state}, 32'h0);
        chk("R1 mid reset result", result, 32'h0);
        chk("R1 mid reset wr_n", {31'h0, mem_wr_n}, 32'h1);
        cmd_in = W_NOP;
        rst_n = 1'b1;
        do_rd(32'h0000_0010, 32'h0000_00AA);
        chk("R1 aborted write left memory", mem[10'h070], 32'h0);

        // R8: address word with an unknown-op top nibble does not set error
        do_wr(32'h5000_0060, 32'h0000_0042);
        chk("R8 address not decoded", {23'h0, ctl_state}, 32'h0);
        do_rd(32'h0000_0060, 32'h0000_0042);

        // R2: top nibble 0xF is unknown
        send(32'hF000_0000);
        @(negedge clk);
        chk("R2 code F is unknown", {23'h0, ctl_state}, 32'h0000_0100);
        cmd_in = W_NOP;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule